// File: doc/BRIEF.md
# Host-Controller Configuration Status Register

This block holds the 16-bit status word of a bus-master host-controller function's configuration space. Error strobes from the controller's master and target logic land in sticky flag bits. Software reads the whole word through a simple register port and clears flags by writing ones to them, with a byte enable for each half. Two command-register enables gate some of the flags: the system-error enable and the parity-response enable.

The block also drives two requests. The first is a halt level for the DMA engines, raised by any abort the function receives as a master. The second is a system-error request. Bit 3 shows the raw interrupt level directly, ahead of any enable gate. The other read-only bits return fixed capability values and a DEVSEL timing code.

The halt request comes from a two-state machine. State `HS_RUN` moves to `HS_HALT` on a master or target abort. `HS_HALT` returns to `HS_RUN` on `halt_clr`, unless an abort arrives in the same cycle, in which case it stays in `HS_HALT`.

Top module: `pci_sts_reg`

## Requirements
- R1: After reset, with `irq_raw` low, `rd_data` reads 16'h0290, and `dma_halt` and `serr_req` are 0.
- R2: Bits 11, 6, 5 and 2:0 always read 0. Bits 7 and 4 always read 1. Bits 10:9 always read 2'b01. Writes never change any of these bits.
- R3: `rd_data[3]` equals `irq_raw` in the same cycle, whatever the other inputs hold.
- R4: A cycle with `ev_parity` high makes bit 15 read 1 from the next cycle, whatever `cmd_serr_en` and `cmd_perr_resp` hold.
- R5: `serr_req` is high in a cycle exactly when `cmd_serr_en` is 1 and at least one of `ev_sig_serr`, `ev_mabort` or `ev_tabort` is 1. Bit 14 reads 1 from the cycle after any cycle in which `serr_req` was high, and is not set otherwise.
- R6: `ev_mabort` sets bit 13 and `ev_tabort` sets bit 12 from the next cycle. Neither depends on the command enables.
- R7: `ev_rd_dpe` sets bit 8 from the next cycle only when `cmd_perr_resp` is 1. When `cmd_perr_resp` is 0, it leaves bit 8 unchanged.
- R8: A write with `wr_en` and `wr_be[1]` high clears each of flag bits 15, 14, 13, 12 and 8 whose `wr_data` bit is 1, from the next cycle. Flag bits written with 0 keep their value.
- R9: A write with `wr_be[1]` low clears no flag, even when `wr_data` is all ones.
- R10: When a set event and a clearing write hit the same flag in the same cycle, the flag reads 1 afterwards.
- R11: `dma_halt` rises in the cycle after `ev_mabort` or `ev_tabort` and holds until a cycle with `halt_clr` high and no abort. It falls in the cycle after that one.
- R12: Without a set event or a clearing write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_parity | input | 1 | Parity error seen by the function |
| ev_sig_serr | input | 1 | Function signals a system error |
| ev_mabort | input | 1 | Master abort received on a memory access |
| ev_tabort | input | 1 | Target abort received on a memory access |
| ev_rd_dpe | input | 1 | Data parity error in a read completion |
| cmd_serr_en | input | 1 | Command system-error enable |
| cmd_perr_resp | input | 1 | Command parity-response enable |
| irq_raw | input | 1 | Interrupt level before the enable gate |
| halt_clr | input | 1 | Releases the DMA halt request |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables, bit 1 covers bits 15:8 |
| wr_data | input | 16 | Write data, ones clear flags |
| rd_data | output | 16 | Current status word |
| dma_halt | output | 1 | Sticky DMA halt request |
| serr_req | output | 1 | System-error request |

## Verification
The hardest cases are those where two inputs act on the same state bit in one cycle. One is a set event arriving together with a clearing write to the same flag. The other is an abort arriving together with `halt_clr`. From the ports, these cases need the flag or the halt to be set first and then both stimuli driven in one cycle. The stimulus builds up that state, issues the colliding cycle, and then reads for a flag or halt that survived. A bench model kept apart from the RTL predicts the expected value. Byte-enable-gated writes of all ones follow the same pattern, sent right after the flags have been set.

// File: rtl/pci_sts_pkg.sv
package pci_sts_pkg;

    localparam int REG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int BE_W    = REG_W / BYTE_W;
    localparam int NFLAG   = 5;

    // flag slots: 0 parity, 1 system error, 2 master abort, 3 target abort, 4 read data parity
    localparam int FLAG_POS [NFLAG] = '{15, 14, 13, 12, 8};

    localparam int          DEVT_LO    = 9;
    localparam logic [15:0] FIXED_ONES = 16'h0090;

    typedef enum logic {
        HS_RUN  = 1'b0,
        HS_HALT = 1'b1
    } halt_st_e;

endpackage

// File: rtl/sts_flag.sv
module sts_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/sts_wr_decode.sv
module sts_wr_decode
    import pci_sts_pkg::*;
(
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [NFLAG-1:0]  clr_o
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_clr
        localparam int POS  = FLAG_POS[i];
        localparam int LANE = POS / BYTE_W;
        assign clr_o[i] = wr_en & wr_be[LANE] & wr_data[POS];
    end

    logic unused_wr;
    assign unused_wr = ^{wr_data, wr_be};

endmodule

// File: rtl/sts_halt_fsm.sv
module sts_halt_fsm
    import pci_sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic clr_i,
    output logic halt_o
);

    halt_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= HS_RUN;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_RUN:  if (abort_i) st_d = HS_HALT;
            HS_HALT: if (clr_i && !abort_i) st_d = HS_RUN;
            default: st_d = HS_RUN;
        endcase
    end

    always_comb begin
        halt_o = 1'b0;
        unique case (st_q)
            HS_RUN:  halt_o = 1'b0;
            HS_HALT: halt_o = 1'b1;
            default: halt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pci_sts_reg.sv
module pci_sts_reg
    import pci_sts_pkg::*;
#(
    parameter logic [1:0] DEVT_CODE = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_parity,
    input  logic              ev_sig_serr,
    input  logic              ev_mabort,
    input  logic              ev_tabort,
    input  logic              ev_rd_dpe,
    input  logic              cmd_serr_en,
    input  logic              cmd_perr_resp,
    input  logic              irq_raw,
    input  logic              halt_clr,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              dma_halt,
    output logic              serr_req
);

    logic             abort_any;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flag_q;

    assign abort_any = ev_mabort | ev_tabort;
    assign serr_req  = cmd_serr_en & (ev_sig_serr | abort_any);

    assign set_v[0] = ev_parity;
    assign set_v[1] = serr_req;
    assign set_v[2] = ev_mabort;
    assign set_v[3] = ev_tabort;
    assign set_v[4] = ev_rd_dpe & cmd_perr_resp;

    sts_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .clr_o   (clr_v)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        sts_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (flag_q[i])
        );
    end

    sts_halt_fsm u_halt (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (abort_any),
        .clr_i   (halt_clr),
        .halt_o  (dma_halt)
    );

    always_comb begin
        rd_data = FIXED_ONES;
        rd_data[DEVT_LO +: 2] = DEVT_CODE;
        rd_data[3] = irq_raw;
        for (int i = 0; i < NFLAG; i++)
            rd_data[FLAG_POS[i]] = flag_q[i];
    end

endmodule

// File: rtl/pci_sts_chk.sv
module pci_sts_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_parity,
    input logic        ev_mabort,
    input logic        ev_tabort,
    input logic        ev_rd_dpe,
    input logic        cmd_perr_resp,
    input logic        halt_clr,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        dma_halt,
    input logic        serr_req
);

    AST_PARITY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_parity |=> rd_data[15]); // R4

    AST_SERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |=> rd_data[14]); // R5

    AST_MABORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mabort |=> rd_data[13]); // R6

    AST_TABORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tabort |=> rd_data[12]); // R6

    AST_DPED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_dpe && cmd_perr_resp) |=> rd_data[8]); // R7

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[1] && wr_data[13] && !ev_mabort) |=> !rd_data[13]); // R8

    AST_BE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] && !(wr_en && wr_be[1])) |=> rd_data[15]); // R9

    AST_HALT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mabort || ev_tabort) |=> dma_halt); // R11

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt && !halt_clr) |=> dma_halt); // R11

    AST_HALT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt && halt_clr && !ev_mabort && !ev_tabort) |=> !dma_halt); // R11

endmodule

bind pci_sts_reg pci_sts_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_parity     (ev_parity),
    .ev_mabort     (ev_mabort),
    .ev_tabort     (ev_tabort),
    .ev_rd_dpe     (ev_rd_dpe),
    .cmd_perr_resp (cmd_perr_resp),
    .halt_clr      (halt_clr),
    .wr_en         (wr_en),
    .wr_be         (wr_be),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .dma_halt      (dma_halt),
    .serr_req      (serr_req)
);

// File: tb/sim_pci_sts_reg.sv
`timescale 1ns/1ps
module sim_pci_sts_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_parity, ev_sig_serr, ev_mabort, ev_tabort, ev_rd_dpe;
    logic        cmd_serr_en, cmd_perr_resp, irq_raw, halt_clr, wr_en;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        dma_halt, serr_req;

    always #2.5 clk = ~clk;

    pci_sts_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_parity(ev_parity), .ev_sig_serr(ev_sig_serr),
        .ev_mabort(ev_mabort), .ev_tabort(ev_tabort), .ev_rd_dpe(ev_rd_dpe),
        .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
        .irq_raw(irq_raw), .halt_clr(halt_clr),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .dma_halt(dma_halt), .serr_req(serr_req)
    );

    typedef struct packed {
        logic [15:0] rd;
        logic        halt;
        logic        serr;
        logic [7:0]  req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    // reference state kept by the bench
    logic m_par, m_sse, m_ma, m_ta, m_dped, m_halt;

    task automatic idle();
        ev_parity = 0; ev_sig_serr = 0; ev_mabort = 0; ev_tabort = 0;
        ev_rd_dpe = 0; halt_clr = 0; wr_en = 0; wr_be = 2'b00; wr_data = 16'h0;
    endtask

    // driver: predict the state after the coming edge, queue it, wait for the next negedge
    task automatic cyc(input int req);
        exp_t e;
        logic clr_ok, serr_now;
        clr_ok   = wr_en & wr_be[1];
        serr_now = cmd_serr_en & (ev_sig_serr | ev_mabort | ev_tabort);
        m_par  = ev_parity | (m_par  & ~(clr_ok & wr_data[15]));
        m_sse  = serr_now  | (m_sse  & ~(clr_ok & wr_data[14]));
        m_ma   = ev_mabort | (m_ma   & ~(clr_ok & wr_data[13]));
        m_ta   = ev_tabort | (m_ta   & ~(clr_ok & wr_data[12]));
        m_dped = (ev_rd_dpe & cmd_perr_resp) | (m_dped & ~(clr_ok & wr_data[8]));
        if (ev_mabort | ev_tabort) m_halt = 1'b1;
        else if (halt_clr)         m_halt = 1'b0;
        e.rd   = {m_par, m_sse, m_ma, m_ta, 1'b0, 2'b01, m_dped,
                  1'b1, 2'b00, 1'b1, irq_raw, 3'b000};
        e.halt = m_halt;
        e.serr = serr_now;
        e.req  = req[7:0];
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: after each edge, compare against the oldest queued item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total += 3;
                if (rd_data !== e.rd) begin
                    bad++;
                    $display("FAIL R%0d rd_data actual=%h expected=%h", e.req, rd_data, e.rd);
                end
                if (dma_halt !== e.halt) begin
                    bad++;
                    $display("FAIL R%0d dma_halt actual=%b expected=%b", e.req, dma_halt, e.halt);
                end
                if (serr_req !== e.serr) begin
                    bad++;
                    $display("FAIL R%0d serr_req actual=%b expected=%b", e.req, serr_req, e.serr);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        cmd_serr_en = 0; cmd_perr_resp = 0; irq_raw = 0;
        m_par = 0; m_sse = 0; m_ma = 0; m_ta = 0; m_dped = 0; m_halt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc(1); cyc(1);                                             // R1 reset word
        irq_raw = 1; cyc(3);                                        // R3 raw level shown
        cmd_serr_en = 1; cyc(3); cmd_serr_en = 0; irq_raw = 0; cyc(3);
        ev_parity = 1; cyc(4); idle(); cyc(4);                      // R4 no enables needed
        ev_sig_serr = 1; cyc(5); idle(); cyc(5);                    // R5 enable off: no flag
        cmd_serr_en = 1; ev_sig_serr = 1; cyc(5); idle(); cyc(5);   // R5 enable on
        cmd_serr_en = 0; ev_mabort = 1; cyc(6); idle(); cyc(11);    // R6 R11 halt rises
        repeat (3) cyc(12);                                         // R12 sticky, halt holds
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h0000; cyc(8);       // R8 zeros keep flags
        wr_be = 2'b01; wr_data = 16'hFFFF; cyc(9);                  // R9 upper lane off
        wr_be = 2'b00; cyc(9); idle(); cyc(9);
        wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; cyc(2);       // R2 R8 clear all, constants stay
        idle(); cyc(8);
        halt_clr = 1; cyc(11); idle(); cyc(11);                     // R11 halt released
        ev_tabort = 1; halt_clr = 1; cyc(11); idle(); cyc(6);       // R11 R6 abort beats release
        halt_clr = 1; cyc(11); idle(); cyc(11);
        cmd_serr_en = 1; ev_tabort = 1; cyc(5); idle(); cmd_serr_en = 0; cyc(5);
        ev_rd_dpe = 1; cyc(7); idle(); cyc(7);                      // R7 gate closed
        cmd_perr_resp = 1; ev_rd_dpe = 1; cyc(7); idle(); cyc(7);   // R7 gate open
        cmd_perr_resp = 0; cyc(12);
        ev_parity = 1; wr_en = 1; wr_be = 2'b10; wr_data = 16'h8000; cyc(10); // R10 set wins
        idle(); cyc(10);
        ev_mabort = 1; wr_en = 1; wr_be = 2'b10; wr_data = 16'hF100; cyc(10); // R10 abort vs clear
        idle(); cyc(10); cyc(12);
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h4100; cyc(8);       // R8 selective clear
        idle(); cyc(8);
        wr_en = 1; wr_be = 2'b11; wr_data = 16'h0EFF; cyc(2);       // R2 read-only bits
        idle(); irq_raw = 1; cyc(3); irq_raw = 0; cyc(3);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule